// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read-data path of a byte-wide nonvolatile memory model. It reports whether a self-timed internal programming cycle has finished. While the memory's busy flag is high, every accepted read returns a status byte instead of array contents. That byte carries two independent end-of-write indicators, so a host can poll in either of two ways. The first is a polarity marker: the inverse of the top bit of the most recently written byte. A host that saved the last byte it wrote compares this bit with its own copy. The second is an alternating bit that changes on every read while busy. A host that saved nothing reads twice and compares the two results. Once busy drops, reads return true array data.

A read is accepted only when the read-request valid is high and both active-low select and output-enable inputs are low. The array address is passed through in the same cycle, and the array supplies its data combinationally in that cycle. The response appears one clock later with a response-valid pulse. The response path has no ready input and cannot be stalled: a response is presented for exactly one cycle and the consumer must take it then. The request side is always ready.

Top module: `wr_done_status`

## Requirements
- R1: After reset, resp_valid is 0, resp_data is all zeros, and the alternating bit is 0, so the first busy read after reset shows 0 on data bit 6.
- R2: A read is accepted in a cycle exactly when req_valid is 1, sel_n is 0 and oe_n is 0. resp_valid is 1 in the next cycle exactly when a read was accepted.
- R3: arr_addr equals req_addr in the same cycle, with no register between them.
- R4: A read accepted while busy is 1 returns, on data bit 7, the inverse of bit 7 of last_wdata. This holds for any read address.
- R5: Data bit 6 of a busy read equals the alternating bit. The alternating bit inverts after each accepted busy read, so consecutive busy reads show opposite values on bit 6.
- R6: A read accepted while busy is 1 returns 0 on data bits 5 down to 0.
- R7: A read accepted while busy is 0 returns arr_rdata from the cycle of acceptance on all 8 bits.
- R8: The alternating bit keeps its value across idle reads and across busy-cycle strobes that are not accepted because sel_n or oe_n is high.
- R9: A read accepted in the first cycle that busy is 0 after a busy period returns true array data.
- R10: resp_data keeps its previous value in every cycle that follows a cycle with no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request strobe |
| sel_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output enable |
| req_addr | input | 13 | Read address |
| busy | input | 1 | Internal programming cycle in progress |
| last_wdata | input | 8 | Most recently written data byte |
| arr_addr | output | 13 | Address to the array read port |
| arr_rdata | input | 8 | Array read data for arr_addr, same cycle |
| resp_valid | output | 1 | Read response valid, one cycle pulse |
| resp_data | output | 8 | Read response data or status byte |

## Verification
The random phase holds busy in bursts of varied length and mixes accepted reads with strobes that sel_n or oe_n blocks. This separates a bit 6 that advances on every strobe from one that advances only on accepted busy reads. It also separates a bit that holds while idle from one that clears. last_wdata values with both polarities of bit 7 show whether bit 7 is really inverted or just copied. Random arr_rdata values on idle reads show whether the array data passes through unaltered. Directed sequences cover the first read after reset, a read in the cycle busy falls, and back-to-back busy reads.

// File: rtl/wr_done_status_pkg.sv
package wr_done_status_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned ALT_BIT = DATA_W - 2;
  localparam int unsigned PAD_W = DATA_W - 2;

  typedef enum logic [0:0] {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } resp_src_e;
endpackage

// File: rtl/wr_done_req_gate.sv
module wr_done_req_gate #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              req_valid,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              busy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              accept,
  output logic              busy_accept
);
  // A read needs the strobe with both active-low enables asserted
  always_comb begin
    accept      = req_valid & ~sel_n & ~oe_n;
    busy_accept = accept & busy;
    arr_addr    = req_addr;
  end
endmodule

// File: rtl/wr_done_alt_bit.sv
module wr_done_alt_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic alt_q
);
  // Flips once per accepted busy read, holds otherwise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alt_q <= 1'b0;
    end else if (step) begin
      alt_q <= ~alt_q;
    end
  end
endmodule

// File: rtl/wr_done_status_fmt.sv
module wr_done_status_fmt
  import wr_done_status_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          busy,
  input  logic          alt_bit,
  input  logic [DW-1:0] last_wdata,
  input  logic [DW-1:0] arr_rdata,
  output resp_src_e     src,
  output logic [DW-1:0] next_data
);
  localparam int unsigned PW = DW - 2;

  logic [DW-1:0] status_byte;

  always_comb begin
    status_byte = {~last_wdata[DW-1], alt_bit, {PW{1'b0}}};
    src         = busy ? SRC_STATUS : SRC_ARRAY;
    unique case (src)
      SRC_STATUS: next_data = status_byte;
      default:    next_data = arr_rdata;
    endcase
  end
endmodule

// File: rtl/wr_done_resp_reg.sv
module wr_done_resp_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          valid_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        data_q <= din;
      end
    end
  end
endmodule

// File: rtl/wr_done_status.sv
module wr_done_status
  import wr_done_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_wdata,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  logic              accept;
  logic              busy_accept;
  logic              alt_q;
  resp_src_e         src;
  logic [DATA_W-1:0] next_data;

  wr_done_req_gate #(.ADDR_W(ADDR_W)) u_gate (
    .req_valid  (req_valid),
    .sel_n      (sel_n),
    .oe_n       (oe_n),
    .req_addr   (req_addr),
    .busy       (busy),
    .arr_addr   (arr_addr),
    .accept     (accept),
    .busy_accept(busy_accept)
  );

  wr_done_alt_bit u_alt (
    .clk  (clk),
    .rst_n(rst_n),
    .step (busy_accept),
    .alt_q(alt_q)
  );

  wr_done_status_fmt #(.DW(DATA_W)) u_fmt (
    .busy      (busy),
    .alt_bit   (alt_q),
    .last_wdata(last_wdata),
    .arr_rdata (arr_rdata),
    .src       (src),
    .next_data (next_data)
  );

  wr_done_resp_reg #(.DW(DATA_W)) u_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .din    (next_data),
    .valid_q(resp_valid),
    .data_q (resp_data)
  );
endmodule

// File: rtl/wr_done_status_chk.sv
module wr_done_status_chk
  import wr_done_status_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              sel_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] req_addr,
  input logic              busy,
  input logic [DATA_W-1:0] last_wdata,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [DATA_W-1:0] arr_rdata,
  input logic              resp_valid,
  input logic [DATA_W-1:0] resp_data
);
  logic live;
  logic seen_busy_rd;
  logic prev_alt;
  logic prev_acc;
  logic prev_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live         <= 1'b0;
      seen_busy_rd <= 1'b0;
      prev_alt     <= 1'b0;
      prev_acc     <= 1'b0;
      prev_busy    <= 1'b0;
    end else begin
      live      <= 1'b1;
      prev_acc  <= req_valid & ~sel_n & ~oe_n;
      prev_busy <= busy;
      if (live && prev_acc && prev_busy) begin
        seen_busy_rd <= 1'b1;
        prev_alt     <= resp_data[ALT_BIT];
      end
    end
  end

  // R2
  resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (resp_valid == prev_acc));

  // R3
  addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_addr == req_addr);

  // R4
  poll_bit_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && prev_acc && prev_busy) |-> (resp_data[POLL_BIT] == ~$past(last_wdata[POLL_BIT])));

  // R5
  alt_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && prev_acc && prev_busy && seen_busy_rd) |-> (resp_data[ALT_BIT] != prev_alt));

  // R6
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && prev_acc && prev_busy) |-> (resp_data[PAD_W-1:0] == '0));

  // R7
  idle_data_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && prev_acc && !prev_busy) |-> (resp_data == $past(arr_rdata)));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !prev_acc) |-> $stable(resp_data));
endmodule

bind wr_done_status wr_done_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .sel_n     (sel_n),
  .oe_n      (oe_n),
  .req_addr  (req_addr),
  .busy      (busy),
  .last_wdata(last_wdata),
  .arr_addr  (arr_addr),
  .arr_rdata (arr_rdata),
  .resp_valid(resp_valid),
  .resp_data (resp_data)
);

// File: tb/sim_wr_done_status.sv
`timescale 1ns/1ps
module sim_wr_done_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        sel_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [12:0] req_addr = '0;
  logic        busy = 1'b0;
  logic [7:0]  last_wdata = '0;
  logic [12:0] arr_addr;
  logic [7:0]  arr_rdata = '0;
  logic        resp_valid;
  logic [7:0]  resp_data;

  int total = 0;
  int bad = 0;
  logic m_alt = 1'b0;
  logic [7:0] m_data = '0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_done_status u0 (.*);

  function automatic logic [7:0] exp_byte(input logic b, input logic [7:0] lw,
                                          input logic [7:0] ad, input logic alt);
    return b ? {~lw[7], alt, 6'b0} : ad;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // drive one cycle at negedge, check the registered response at the next negedge
  task automatic cyc(input logic v, input logic sn, input logic on, input logic [12:0] a,
                     input logic b, input logic [7:0] lw, input logic [7:0] ad, input string req);
    logic acc;
    req_valid = v; sel_n = sn; oe_n = on; req_addr = a;
    busy = b; last_wdata = lw; arr_rdata = ad;
    #0.1;
    check("R3 arr_addr", {19'b0, arr_addr}, {19'b0, a});
    acc = v & ~sn & ~on;
    if (acc) m_data = exp_byte(b, lw, ad, m_alt);
    if (acc && b) m_alt = ~m_alt;
    @(posedge clk);
    @(negedge clk);
    check({req, " valid"}, {31'b0, resp_valid}, {31'b0, acc});
    check({req, " data"}, {24'b0, resp_data}, {24'b0, m_data});
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 valid", {31'b0, resp_valid}, 32'd0);
    check("R1 data", {24'b0, resp_data}, 32'd0);
    // R1 first busy read shows alt 0, R4 inverted bit 7, R6 low bits zero
    cyc(1, 0, 0, 13'h0155, 1, 8'h35, 8'hFF, "R1 R4 R6 first busy");
    cyc(1, 0, 0, 13'h0AAA, 1, 8'hC3, 8'h11, "R5 R4 second busy");
    // R2/R8 blocked strobes while busy do not advance alt
    cyc(1, 1, 0, 13'h0001, 1, 8'hC3, 8'h22, "R2 R8 sel blocked");
    cyc(1, 0, 1, 13'h0002, 1, 8'hC3, 8'h33, "R2 R8 oe blocked");
    cyc(0, 0, 0, 13'h0003, 1, 8'hC3, 8'h44, "R10 no strobe");
    cyc(1, 0, 0, 13'h1FFF, 1, 8'hC3, 8'h55, "R5 R8 third busy");
    // R9 read in first idle cycle
    cyc(1, 0, 0, 13'h0004, 0, 8'hC3, 8'hA5, "R9 transition read");
    // R8 idle reads keep alt
    cyc(1, 0, 0, 13'h0005, 0, 8'hC3, 8'h5A, "R7 R8 idle read");
    cyc(1, 0, 0, 13'h0006, 1, 8'h00, 8'h00, "R8 R5 busy after idle");
    // random phase
    begin
      logic b = 1'b0;
      int run = 0;
      logic [7:0] lw = 8'h00;
      for (int i = 0; i < 3000; i++) begin
        if (run == 0) begin
          b = ~b;
          run = 1 + ($urandom % 20);
          if (b) lw = 8'($urandom);
        end
        run--;
        cyc(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
            13'($urandom), b, lw, 8'($urandom), "R2 R4 R5 R6 R7 R8 R10 random");
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule